// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block is one pulse-width modulation channel. It drives a high-side and a low-side output as a complementary pair from a 16-bit counter. The counter advances only on an external clock-enable tick, so a shared prescaler outside the block sets the channel's time base. Software writes the period, the duty value and two 12-bit dead-time values into shadow registers through a one-word write port. The channel copies all of them into its working registers together, at the update point of the counter. A value written in the middle of a cycle therefore never changes the waveform in progress.

The counter runs in edge mode (up to the period, then back to zero) or in symmetric mode (up to the period, then down to zero). The high side wants to be active while the counter is below the duty value, and the low side wants the opposite. A dead-time stage on each side delays that side's activation edge by a programmed number of ticks. A polarity input selects which pin level means active.

Two layers can replace the waveform at the pins. A per-pin override can apply at once or wait for the next update point. A fault input has priority over both the waveform and the override, and forces each pin to a programmed level through combinational logic only.

Top module: `pwm_cdt_channel`

## Requirements
- R1: In edge mode (`center`=0) every tick with `enable`=1 moves `count` up by one. When `count` is greater than or equal to the working period it returns to 0 instead, and that edge is an update point. With `tick`=0, `count` holds its value.
- R2: In symmetric mode (`center`=1) `count` rises to the working period and then falls to 0. The edge that brings `count` back to 0 is an update point. With period P≥1 one cycle lasts 2·P ticks. With P=0, `count` stays 0 and every tick is an update point.
- R3: When `wr_en`=1 on a clock edge, `wr_data` goes into a shadow register chosen by `wr_sel`: 0 selects the period, 1 the duty value, 2 the high-side dead-time (bits 11:0) and 3 the low-side dead-time (bits 11:0). The working copies take the shadow values only at an update point. While `enable`=0, every clock edge is an update point.
- R4: The high side's wanted state is active while `count` is below the working duty value. The low side's wanted state is the inverse.
- R5: A side's pin turns active only after its wanted state has been active for the working dead-time D of that side, counted in ticks. With `tick` held at 1, the pin turns active D+1 clock edges after the `count` value that made it wanted appears. It turns inactive one edge after the wanted state ends.
- R6: If a side's wanted-active stretch is shorter than its dead-time, that side's pin stays inactive for the whole stretch.
- R7: With `pol`=1 the active level of a pin is 1. With `pol`=0 the active level is 0.
- R8: After reset, and one edge after `enable` goes to 0, `count` is 0 and both pins are at the inactive level, unless an override or a fault is applied.
- R9: With `ovr_sync`=0, every pin whose bit in `ovr_en` is 1 takes its `ovr_val` bit at once, through combinational logic. Bit 0 is the high side and bit 1 is the low side.
- R10: With `ovr_sync`=1, the override uses copies of `ovr_en` and `ovr_val` that are sampled only at update points.
- R11: While `fault`=1, `pwm_out` equals `fault_lvl` at once, with priority over the override and the waveform.
- R12: The internal active states of the high side and the low side are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel run enable |
| tick | input | 1 | Clock-enable tick for the counter and the dead-time stages |
| center | input | 1 | 1 selects symmetric counting, 0 selects edge counting |
| pol | input | 1 | Pin level that means active |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow register select (0 period, 1 duty, 2 high-side dead-time, 3 low-side dead-time) |
| wr_data | input | 16 | Write data |
| ovr_en | input | 2 | Per-pin override enable (bit 0 high side, bit 1 low side) |
| ovr_val | input | 2 | Per-pin override level |
| ovr_sync | input | 1 | 1 applies the override at update points, 0 applies it at once |
| fault | input | 1 | Fault request |
| fault_lvl | input | 2 | Pin levels forced while a fault is applied |
| pwm_out | output | 2 | Pins (bit 0 high side, bit 1 low side) |
| count | output | 16 | Current counter value |

## Verification
`count` and the internal active states are registered, so a tick, an enable change or a counter value shows on the ports one edge later. A register write shows at the first update point after its edge. A wanted state shows at a pin D+1 edges later. Fault forcing and immediate override have no latency at all. The bench keeps a cycle-level model that is advanced at each falling edge from the inputs it drove for the rising edge just passed, and compares the ports against it at that falling edge. The combinational paths are checked a few nanoseconds after the input changes, with no clock edge in between. Dead-time delays are measured directly by counting falling edges from the wrap of `count` to the rise of each pin.

// File: rtl/pwm_cdt_pkg.sv
package pwm_cdt_pkg;
    localparam int PWM_CNT_W = 16;
    localparam int PWM_DT_W  = 12;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_DT_HI  = 2'd2,
        SEL_DT_LO  = 2'd3
    } pwm_sel_e;

    localparam int SIDE_HI = 0;
    localparam int SIDE_LO = 1;
    localparam int N_SIDES = 2;
endpackage

// File: rtl/pwm_cdt_regs.sv
module pwm_cdt_regs
    import pwm_cdt_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W,
    parameter int DT_W  = PWM_DT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  pwm_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd,
    input  logic [1:0]       ovr_en,
    input  logic [1:0]       ovr_val,
    output logic [CNT_W-1:0] per_a,
    output logic [CNT_W-1:0] duty_a,
    output logic [DT_W-1:0]  dth_a,
    output logic [DT_W-1:0]  dtl_a,
    output logic [1:0]       sovr_en,
    output logic [1:0]       sovr_val
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dth;
        logic [DT_W-1:0]  dtl;
    } bank_t;

    typedef struct packed {
        bank_t      sh;
        bank_t      act;
        logic [1:0] oen;
        logic [1:0] oval;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_PERIOD: st_d.sh.per  = wr_data;
                SEL_DUTY:   st_d.sh.duty = wr_data;
                SEL_DT_HI:  st_d.sh.dth  = wr_data[DT_W-1:0];
                SEL_DT_LO:  st_d.sh.dtl  = wr_data[DT_W-1:0];
                default:    st_d.sh      = st_q.sh;
            endcase
        end
        if (upd) begin
            st_d.act  = st_q.sh;
            st_d.oen  = ovr_en;
            st_d.oval = ovr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign per_a    = st_q.act.per;
    assign duty_a   = st_q.act.duty;
    assign dth_a    = st_q.act.dth;
    assign dtl_a    = st_q.act.dtl;
    assign sovr_en  = st_q.oen;
    assign sovr_val = st_q.oval;
endmodule

// File: rtl/pwm_cdt_timebase.sv
module pwm_cdt_timebase
    import pwm_cdt_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             center,
    input  logic [CNT_W-1:0] per_a,
    output logic [CNT_W-1:0] count,
    output logic             upd
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        upd  = 1'b0;
        if (!enable) begin
            tb_d = '0;
            upd  = 1'b1;
        end else if (tick) begin
            if (!center) begin
                tb_d.down = 1'b0;
                if (tb_q.cnt >= per_a) begin
                    tb_d.cnt = '0;
                    upd      = 1'b1;
                end else begin
                    tb_d.cnt = tb_q.cnt + ONE;
                end
            end else if (!tb_q.down) begin
                if (tb_q.cnt >= per_a) begin
                    if (tb_q.cnt <= ONE) begin
                        tb_d.cnt  = '0;
                        tb_d.down = 1'b0;
                        upd       = 1'b1;
                    end else begin
                        tb_d.cnt  = tb_q.cnt - ONE;
                        tb_d.down = 1'b1;
                    end
                end else begin
                    tb_d.cnt = tb_q.cnt + ONE;
                end
            end else begin
                tb_d.cnt = tb_q.cnt - ONE;
                if (tb_q.cnt == ONE) begin
                    tb_d.down = 1'b0;
                    upd       = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign count = tb_q.cnt;
endmodule

// File: rtl/pwm_cdt_deadtime.sv
module pwm_cdt_deadtime
    import pwm_cdt_pkg::*;
#(
    parameter int DT_W = PWM_DT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            tick,
    input  logic            want,
    input  logic [DT_W-1:0] dt,
    output logic            act
);
    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    typedef struct packed {
        logic [DT_W-1:0] wait_cnt;
        logic            on;
    } dt_t;

    dt_t dt_d, dt_q;

    always_comb begin
        dt_d = dt_q;
        if (!enable || !want) begin
            dt_d = '0;
        end else if (!dt_q.on) begin
            if (dt_q.wait_cnt >= dt) dt_d.on = 1'b1;
            else if (tick)           dt_d.wait_cnt = dt_q.wait_cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dt_q <= '0;
        else        dt_q <= dt_d;
    end

    assign act = dt_q.on;
endmodule

// File: rtl/pwm_cdt_channel.sv
module pwm_cdt_channel
    import pwm_cdt_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W,
    parameter int DT_W  = PWM_DT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             center,
    input  logic             pol,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       ovr_en,
    input  logic [1:0]       ovr_val,
    input  logic             ovr_sync,
    input  logic             fault,
    input  logic [1:0]       fault_lvl,
    output logic [1:0]       pwm_out,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] per_a, duty_a;
    logic [DT_W-1:0]  dth_a, dtl_a;
    logic [1:0]       sovr_en, sovr_val;
    logic             upd;
    logic             ref_hi;
    logic [N_SIDES-1:0] want, act;
    logic [DT_W-1:0]  dt_v [N_SIDES];

    pwm_cdt_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (pwm_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .upd      (upd),
        .ovr_en   (ovr_en),
        .ovr_val  (ovr_val),
        .per_a    (per_a),
        .duty_a   (duty_a),
        .dth_a    (dth_a),
        .dtl_a    (dtl_a),
        .sovr_en  (sovr_en),
        .sovr_val (sovr_val)
    );

    pwm_cdt_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (tick),
        .center (center),
        .per_a  (per_a),
        .count  (count),
        .upd    (upd)
    );

    assign ref_hi        = (count < duty_a);
    assign want[SIDE_HI] = ref_hi;
    assign want[SIDE_LO] = ~ref_hi;
    assign dt_v[SIDE_HI] = dth_a;
    assign dt_v[SIDE_LO] = dtl_a;

    for (genvar gi = 0; gi < N_SIDES; gi++) begin : g_side
        pwm_cdt_deadtime #(.DT_W(DT_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .tick   (tick),
            .want   (want[gi]),
            .dt     (dt_v[gi]),
            .act    (act[gi])
        );
    end

    always_comb begin
        for (int i = 0; i < N_SIDES; i++) begin
            logic oe, ov, wave;
            wave = act[i] ~^ pol;
            oe   = ovr_sync ? sovr_en[i]  : ovr_en[i];
            ov   = ovr_sync ? sovr_val[i] : ovr_val[i];
            if (fault)   pwm_out[i] = fault_lvl[i];
            else if (oe) pwm_out[i] = ov;
            else         pwm_out[i] = wave;
        end
    end
endmodule

// File: rtl/pwm_cdt_channel_chk.sv
module pwm_cdt_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tick,
    input logic             fault,
    input logic [1:0]       fault_lvl,
    input logic [1:0]       ovr_en,
    input logic [1:0]       ovr_val,
    input logic             ovr_sync,
    input logic [1:0]       pwm_out,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] per_a,
    input logic [1:0]       act
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= per_a); // R1
    AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(count)); // R1
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (act == 2'b00 && count == '0)); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        act != 2'b11); // R12
    AST_ASYNC_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !ovr_sync && ovr_en[0]) |-> pwm_out[0] == ovr_val[0]); // R9
    AST_FAULT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> pwm_out == fault_lvl); // R11
endmodule

bind pwm_cdt_channel pwm_cdt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .fault     (fault),
    .fault_lvl (fault_lvl),
    .ovr_en    (ovr_en),
    .ovr_val   (ovr_val),
    .ovr_sync  (ovr_sync),
    .pwm_out   (pwm_out),
    .count     (count),
    .per_a     (per_a),
    .act       (act)
);

// File: tb/pwm_cdt_channel_tb.sv
module pwm_cdt_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 0, tick = 0, center = 0, pol = 1, wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [15:0] wr_data = 0;
    logic [1:0]  ovr_en = 0, ovr_val = 0, fault_lvl = 0;
    logic        ovr_sync = 0, fault = 0;
    logic [1:0]  pwm_out;
    logic [15:0] count;

    int errors = 0, checks = 0;
    bit done = 0;
    string tag = "R8";

    // bench model state
    int m_cnt = 0, m_per = 0, m_duty = 0, m_dt[2] = '{0, 0};
    int s_per = 0, s_duty = 0, s_dt[2] = '{0, 0};
    bit m_down = 0, m_on[2] = '{0, 0};
    int m_run[2] = '{0, 0};
    bit [1:0] m_soen = 0, m_soval = 0;

    always #10 clk = ~clk;

    pwm_cdt_channel u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .center(center),
        .pol(pol), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ovr_en(ovr_en), .ovr_val(ovr_val), .ovr_sync(ovr_sync),
        .fault(fault), .fault_lvl(fault_lvl), .pwm_out(pwm_out), .count(count)
    );

    task automatic chk(string t, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act_v, exp_v, $time);
        end
    endtask

    function automatic bit [1:0] exp_pins();
        bit [1:0] r;
        for (int i = 0; i < 2; i++) begin
            bit oe, ov, wave;
            wave = pol ? m_on[i] : !m_on[i];
            oe = ovr_sync ? m_soen[i] : ovr_en[i];
            ov = ovr_sync ? m_soval[i] : ovr_val[i];
            r[i] = fault ? fault_lvl[i] : (oe ? ov : wave);
        end
        return r;
    endfunction

    task automatic cyc();
        int  n_cnt = m_cnt;
        bit  n_down = m_down;
        bit  upd = 0;
        bit  want[2];
        bit  n_on[2];
        int  n_run[2];
        want[0] = (m_cnt < m_duty);
        want[1] = !want[0];
        for (int i = 0; i < 2; i++) begin
            n_on[i] = m_on[i];
            n_run[i] = m_run[i];
            if (!enable || !want[i]) begin
                n_on[i] = 0; n_run[i] = 0;
            end else if (!m_on[i]) begin
                if (m_run[i] >= m_dt[i]) n_on[i] = 1;
                else if (tick) n_run[i] = m_run[i] + 1;
            end
        end
        if (!enable) begin
            n_cnt = 0; n_down = 0; upd = 1;
        end else if (tick) begin
            if (!center) begin
                n_down = 0;
                if (m_cnt >= m_per) begin n_cnt = 0; upd = 1; end
                else n_cnt = m_cnt + 1;
            end else if (!m_down) begin
                if (m_cnt >= m_per) begin
                    if (m_cnt <= 1) begin n_cnt = 0; n_down = 0; upd = 1; end
                    else begin n_cnt = m_cnt - 1; n_down = 1; end
                end else n_cnt = m_cnt + 1;
            end else begin
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) begin n_down = 0; upd = 1; end
            end
        end
        if (upd) begin
            m_per = s_per; m_duty = s_duty; m_dt[0] = s_dt[0]; m_dt[1] = s_dt[1];
            m_soen = ovr_en; m_soval = ovr_val;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: s_per = wr_data;
                2'd1: s_duty = wr_data;
                2'd2: s_dt[0] = wr_data & 16'h0fff;
                default: s_dt[1] = wr_data & 16'h0fff;
            endcase
        end
        @(negedge clk);
        m_cnt = n_cnt; m_down = n_down;
        m_on = n_on; m_run = n_run;
        chk(tag, count, m_cnt);
        chk(tag, pwm_out, exp_pins());
        if (pol && !fault && (ovr_sync ? m_soen == 0 : ovr_en == 0))
            chk("R12", (pwm_out == 2'b11), 0);
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1; wr_sel = sel[1:0]; wr_data = data[15:0];
        cyc();
        wr_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pers[4] = '{0, 1, 3, 6};
        repeat (3) @(negedge clk);
        chk("R8", count, 0);
        chk("R8", pwm_out, 0);
        rst_n = 1;
        tick = 1;
        // R8 / R3: writes while disabled apply at once, pins stay inactive
        tag = "R8";
        wr(0, 5); wr(1, 2); wr(2, 1); wr(3, 2);
        repeat (4) cyc();
        chk("R3", pwm_out, 0);
        // R1 / R2 / R4 sweeps
        enable = 1;
        for (int md = 0; md < 2; md++) begin
            center = md[0];
            tag = md ? "R2" : "R1";
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 3; k++)
                    for (int d = 0; d < 2; d++) begin
                        int dv = (k == 0) ? 0 : (k == 1) ? pers[p] / 2 + 1 : pers[p] + 1;
                        wr(0, pers[p]); wr(1, dv); wr(2, d); wr(3, d);
                        repeat (4 * pers[p] + 10) cyc();
                    end
        end
        // R1: irregular tick
        tag = "R1"; center = 0;
        wr(0, 4); wr(1, 2);
        for (int i = 0; i < 40; i++) begin tick = (i % 3 == 0); cyc(); end
        tick = 1;
        // R3: period written mid-cycle keeps the cycle in progress
        tag = "R3";
        wr(0, 6); repeat (20) cyc();
        while (count != 2) cyc();
        wr(0, 2);
        chk("R3", count, 3);
        cyc(); cyc(); cyc();
        chk("R3", count, 6);
        repeat (10) cyc();
        // R5: dead-time delays measured from the wrap
        tag = "R5";
        wr(0, 9); wr(1, 5); wr(2, 2); wr(3, 3);
        repeat (25) cyc();
        while (count != 0) cyc();
        begin
            int n = 0;
            while (pwm_out[0] == 0 && n < 20) begin cyc(); n++; end
            chk("R5", n, 3);
            while (count != 5) cyc();
            n = 0;
            while (pwm_out[1] == 0 && n < 20) begin cyc(); n++; end
            chk("R5", n, 4);
        end
        // R4: compare boundary at duty
        tag = "R4";
        wr(2, 0); wr(3, 0); repeat (25) cyc();
        while (count != 5) cyc();
        chk("R4", pwm_out, 2'b01);
        cyc();
        chk("R4", pwm_out, 2'b10);
        // R6: dead-time longer than the active width
        tag = "R6";
        wr(0, 7); wr(1, 3); wr(2, 5); repeat (25) cyc();
        begin
            bit seen = 0;
            for (int i = 0; i < 16; i++) begin cyc(); seen |= pwm_out[0]; end
            chk("R6", seen, 0);
        end
        // R7: inverted polarity
        tag = "R7"; pol = 0;
        wr(2, 1); repeat (30) cyc();
        // R9: immediate override
        tag = "R9"; ovr_sync = 0; ovr_en = 2'b01; ovr_val = 2'b00;
        #2 chk("R9", pwm_out[0], 0);
        repeat (12) cyc();
        ovr_en = 2'b00; pol = 1;
        // R10: override held until the update point
        tag = "R10"; ovr_sync = 1; ovr_en = 2'b10; ovr_val = 2'b10;
        repeat (30) cyc();
        ovr_en = 2'b00; repeat (20) cyc();
        ovr_sync = 0;
        // R11: fault forcing
        tag = "R11"; fault = 1; fault_lvl = 2'b10; ovr_en = 2'b11; ovr_val = 2'b01;
        #2 chk("R11", pwm_out, 2'b10);
        repeat (10) cyc();
        fault = 0; ovr_en = 0;
        // R8: disable drops pins one edge later
        tag = "R8"; repeat (5) cyc();
        enable = 0; cyc();
        chk("R8", count, 0);
        chk("R8", pwm_out, 0);
        repeat (5) cyc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule